// File: doc/BRIEF.md
# Banked GPIO Output, Direction and Level Port

This block is a memory-mapped general purpose I/O port. It serves a number of pads arranged in banks of 32 pins: six banks, 192 pins, by default. Software reaches it over a simple word-addressed register bus with separate read and write strobes. For every pad the block drives an output value and an output enable, and it samples the pad's input value through a two-flop synchroniser.

There are four register types, and each one fills a region of consecutive words with one word per bank. The level region is read-only and returns the synchronised pin states. The direction region is read/write; a 1 selects output. The set and clear regions are write-only. They change single output bits with no read-modify-write: writing 1 to a bit of set drives that pin high, writing 1 to a bit of clear drives it low, and 0 bits leave the pin alone. Pin n lives in word (region base + n / 32) at bit n mod 32. In bus words, the region bases are 1 (level), 7 (direction), 13 (set) and 19 (clear). In bytes these are 0x004, 0x01C, 0x034 and 0x04C.

Top module: `gpio_bank_port`

## Requirements
- R1: While reset is low and in the first cycle after it rises, every output enable is 0, every output value is 0 and the read data is 0.
- R2: A read of level word 1+b returns input pins 32b to 32b+31 after synchronisation, with bit i being pin 32b+i, once the inputs have been stable for three clock edges.
- R3: A write to direction word 7+b replaces that bank's direction bits, and a later read of that word returns them. Output enable of pin 32b+i equals direction bit i, where 1 means output. Output enables change only on a direction write.
- R4: Writing to set word 13+b drives output value high on every pin 32b+i whose data bit i is 1. Pins whose data bit is 0 keep their value.
- R5: Writing to clear word 19+b drives output value low on every pin 32b+i whose data bit i is 1. Pins whose data bit is 0 keep their value.
- R6: Reads of the set and clear words return zero.
- R7: Reads of unmapped words (word 0 and words 25 and above) return zero. Writes to unmapped words and to level words change no output value and no output enable.
- R8: A write to a word of one bank changes the pins of that bank only.
- R9: Read data appears on bus_rdata in the cycle after the read strobe. A change on an input pin shows up in a level read issued at the third clock edge after the change, and not in a read issued earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd, else 0 |
| pad_in | input | NUM_BANKS*32 | Pad input values |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables |

## Verification
A wrong output or direction bit shows on pad_out or pad_oe at the edge that caused it. It becomes visible on bus_rdata one cycle after the next read of that word. A decode error that picks the wrong bank or region corrupts a different bank's pins at the write edge, or returns non-zero data from a write-only or unmapped word in the cycle after the read. A synchroniser with too few or too many stages moves the moment a level read sees a new input by one cycle, which the per-clock model exposes on the first read after an input change.

// File: rtl/gpio_bank_pkg.sv
// Shared types for the banked GPIO port.
// Assumes the four register regions are laid out back to back, one word per bank.
package gpio_bank_pkg;
    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_LEVEL,
        KIND_DIR,
        KIND_SET,
        KIND_CLR
    } reg_kind_e;

    // Word address of the first region; word 0 stays unmapped.
    localparam int unsigned FIRST_REGION_WORD = 1;
    localparam int unsigned NUM_REGIONS       = 4;
    localparam int unsigned BANK_W            = 32;
endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: maps a word address onto a register kind and a bank index.
// Assumes NUM_BANKS >= 2 and that region k starts at FIRST_REGION_WORD + k*NUM_BANKS.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned NUM_BANKS  = 6,
    parameter int unsigned BANK_IDX_W = $clog2(NUM_BANKS)
) (
    input  logic [ADDR_W-1:0]     addr,
    output reg_kind_e             kind,
    output logic [BANK_IDX_W-1:0] bank
);
    function automatic reg_kind_e kind_of(input int unsigned k);
        case (k)
            0:       return KIND_LEVEL;
            1:       return KIND_DIR;
            2:       return KIND_SET;
            default: return KIND_CLR;
        endcase
    endfunction

    // Find the region the address falls in and its offset within that region.
    always_comb begin
        kind = KIND_NONE;
        bank = '0;
        for (int unsigned k = 0; k < NUM_REGIONS; k++) begin
            if (int'(addr) >= int'(FIRST_REGION_WORD + k * NUM_BANKS) &&
                int'(addr) <  int'(FIRST_REGION_WORD + (k + 1) * NUM_BANKS)) begin
                kind = kind_of(k);
                bank = BANK_IDX_W'(int'(addr) - int'(FIRST_REGION_WORD + k * NUM_BANKS));
            end
        end
    end
endmodule

// File: rtl/gpio_sync2.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is provided.
module gpio_sync2 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    // Shift the inputs through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_bank_slice.sv
// One 32-pin bank: direction word plus output word with set/clear masks.
// Assumes at most one of the write enables is active per cycle; if two are, set beats clear.
module gpio_bank_slice #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);
    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;

    // Turn the write data into per-bit set and clear masks.
    always_comb begin
        set_mask = set_we ? wdata : '0;
        clr_mask = clr_we ? wdata : '0;
    end

    // Direction word: full-word replace on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_we) begin
            dir_q <= wdata;
        end
    end

    // Output word: clear the masked bits, then set the masked bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= (out_q & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/gpio_bank_port.sv
// Banked GPIO port top: bus decode, per-bank registers, input sync, read mux.
// Assumes a single-beat bus; read data is registered and is zero when no read was issued.
module gpio_bank_port
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_BANKS = 6,
    localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W,
    localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BANK_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [BANK_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    reg_kind_e             acc_kind;
    logic [BANK_IDX_W-1:0] acc_bank;
    logic [NUM_PINS-1:0]   level_sync;
    logic [BANK_W-1:0]     level_words [NUM_BANKS];
    logic [BANK_W-1:0]     dir_words   [NUM_BANKS];
    logic [BANK_W-1:0]     rd_word;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_IDX_W(BANK_IDX_W)
    ) decode_i (
        .addr(bus_addr),
        .kind(acc_kind),
        .bank(acc_bank)
    );

    gpio_sync2 #(
        .W(NUM_PINS)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (level_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic [BANK_W-1:0] out_word;

        assign hit = bus_wr && (acc_bank == BANK_IDX_W'(b));

        gpio_bank_slice #(
            .W(BANK_W)
        ) slice_i (
            .clk   (clk),
            .rst_n (rst_n),
            .dir_we(hit && (acc_kind == KIND_DIR)),
            .set_we(hit && (acc_kind == KIND_SET)),
            .clr_we(hit && (acc_kind == KIND_CLR)),
            .wdata (bus_wdata),
            .dir_q (dir_words[b]),
            .out_q (out_word)
        );

        assign level_words[b]               = level_sync[b*BANK_W +: BANK_W];
        assign pad_out[b*BANK_W +: BANK_W]  = out_word;
        assign pad_oe[b*BANK_W +: BANK_W]   = dir_words[b];
    end

    // Select the word a read returns; write-only and unmapped words give zero.
    always_comb begin
        rd_word = '0;
        case (acc_kind)
            KIND_LEVEL: rd_word = level_words[acc_bank];
            KIND_DIR:   rd_word = dir_words[acc_bank];
            default:    rd_word = '0;
        endcase
    end

    // Register the read data for one cycle; it is zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_word : '0;
        end
    end
endmodule

// File: rtl/gpio_bank_port_chk.sv
// Property checker for gpio_bank_port, watching its ports only.
// Assumes the region layout given in gpio_bank_pkg.
module gpio_bank_port_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_BANKS = 6,
    localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [BANK_W-1:0]   bus_wdata,
    input logic                bus_rd,
    input logic [BANK_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);
    localparam int DIR_LO = int'(FIRST_REGION_WORD + NUM_BANKS);
    localparam int SET_LO = int'(FIRST_REGION_WORD + 2 * NUM_BANKS);
    localparam int CLR_LO = int'(FIRST_REGION_WORD + 3 * NUM_BANKS);
    localparam int END_LO = int'(FIRST_REGION_WORD + 4 * NUM_BANKS);

    logic in_dir, in_set, in_clr, in_wo, in_none;
    logic [NUM_PINS-1:0] wide_data, set_pins, clr_pins;

    // Classify the address independently of the design's decoder.
    always_comb begin
        in_dir    = int'(bus_addr) >= DIR_LO && int'(bus_addr) < SET_LO;
        in_set    = int'(bus_addr) >= SET_LO && int'(bus_addr) < CLR_LO;
        in_clr    = int'(bus_addr) >= CLR_LO && int'(bus_addr) < END_LO;
        in_wo     = in_set || in_clr;
        in_none   = int'(bus_addr) < int'(FIRST_REGION_WORD) || int'(bus_addr) >= END_LO;
        wide_data = {{(NUM_PINS-BANK_W){1'b0}}, bus_wdata};
        set_pins  = (bus_wr && in_set) ? wide_data << (BANK_W * (int'(bus_addr) - SET_LO)) : '0;
        clr_pins  = (bus_wr && in_clr) ? wide_data << (BANK_W * (int'(bus_addr) - CLR_LO)) : '0;
    end

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

    // R3
    oe_only_on_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && in_dir) |=> $stable(pad_oe));

    // R4
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_set) |=> ((pad_out & $past(set_pins)) == $past(set_pins)));

    // R5
    clear_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_clr) |=> ((pad_out & $past(clr_pins)) == '0));

    // R6
    write_only_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_wo) |=> (bus_rdata == '0));

    // R7
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_none) |=> (bus_rdata == '0));

    // R7
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_none) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/gpio_bank_port_tb_top.sv
// Self-checking bench: a behavioural per-clock model plus directed checks.
module gpio_bank_port_tb_top;
    localparam int AW = 10;
    localparam int NB = 6;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // Reference model state
    logic [NP-1:0] m_dir = '0, m_out = '0, m_s1 = '0, m_s2 = '0;
    logic [31:0]   m_rdata = '0;

    always #4 clk = ~clk;

    gpio_bank_port #(.ADDR_W(AW), .NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [31:0] model_read(int a);
        if (a >= 1 && a < 1 + NB)          return m_s2[(a-1)*32 +: 32];
        if (a >= 1 + NB && a < 1 + 2*NB)   return m_dir[(a-1-NB)*32 +: 32];
        return 32'h0;
    endfunction

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_s1 = '0; m_s2 = '0; m_rdata = '0;
        end else begin
            int a;
            a = int'(bus_addr);
            m_rdata = bus_rd ? model_read(a) : 32'h0;
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (bus_wr) begin
                if (a >= 1 + NB && a < 1 + 2*NB) m_dir[(a-1-NB)*32 +: 32] = bus_wdata;
                else if (a >= 1 + 2*NB && a < 1 + 3*NB)
                    m_out[(a-1-2*NB)*32 +: 32] = m_out[(a-1-2*NB)*32 +: 32] | bus_wdata;
                else if (a >= 1 + 3*NB && a < 1 + 4*NB)
                    m_out[(a-1-3*NB)*32 +: 32] = m_out[(a-1-3*NB)*32 +: 32] & ~bus_wdata;
            end
        end
    end

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (pad_out !== m_out || pad_oe !== m_dir || bus_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s per-clock: out=%h oe=%h rdata=%h expected out=%h oe=%h rdata=%h",
                         cur_tag, pad_out, pad_oe, bus_rdata, m_out, m_dir, m_rdata);
            end
        end
    end

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [NP-1:0] snap_out, snap_oe;
        pad_in = {6{32'h1234_5678}};
        repeat (3) @(negedge clk);
        // R1: state while in reset
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 rdata", NP'(bus_rdata), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", pad_out | pad_oe, '0);

        // R3: direction write, readback and enables
        cur_tag = "R3";
        wr(7, 32'hA5A5_F00F);
        wr(12, 32'hFFFF_0001);
        rd(7, d);  chk("R3 dir bank0", NP'(d), NP'(32'hA5A5_F00F));
        rd(12, d); chk("R3 dir bank5", NP'(d), NP'(32'hFFFF_0001));
        chk("R3 pad_oe", pad_oe, {32'hFFFF_0001, 128'h0, 32'hA5A5_F00F});

        // R4: set bits, zeros untouched
        cur_tag = "R4";
        wr(15, 32'h0000_00F1);
        wr(15, 32'h0000_0100);
        chk("R4 pad_out bank2", NP'(pad_out[64 +: 32]), NP'(32'h0000_01F1));

        // R6: write-only words read zero
        cur_tag = "R6";
        rd(15, d); chk("R6 set read", NP'(d), '0);
        rd(21, d); chk("R6 clear read", NP'(d), '0);

        // R5: clear bits, zeros untouched
        cur_tag = "R5";
        wr(21, 32'h0000_0011);
        chk("R5 pad_out bank2", NP'(pad_out[64 +: 32]), NP'(32'h0000_01E0));

        // R8: bank boundaries (pin 95 = bank2 bit31, pin 32 = bank1 bit0)
        cur_tag = "R8";
        wr(15, 32'h8000_0000);
        wr(14, 32'h0000_0001);
        chk("R8 pin95", NP'(pad_out[95]), NP'(1'b1));
        chk("R8 pin32", NP'(pad_out[32]), NP'(1'b1));
        chk("R8 other banks", NP'({pad_out[191:96], pad_out[31:0]}), '0);
        wr(24, 32'hFFFF_FFFF);
        chk("R8 clear bank5 keeps bank2", NP'(pad_out[64 +: 32]), NP'(32'h8000_01E0));

        // R2 / R9: level reads and synchroniser latency
        cur_tag = "R2";
        repeat (3) @(negedge clk);
        rd(1, d); chk("R2 level bank0", NP'(d), NP'(32'h1234_5678));
        rd(6, d); chk("R2 level bank5", NP'(d), NP'(32'h1234_5678));
        cur_tag = "R9";
        @(negedge clk);
        pad_in[160 +: 32] = 32'hCAFE_0042;
        bus_addr = AW'(6); bus_rd = 1'b1;
        @(negedge clk);
        chk("R9 first read old", NP'(bus_rdata), NP'(32'h1234_5678));
        @(negedge clk);
        chk("R9 second read old", NP'(bus_rdata), NP'(32'h1234_5678));
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 third read new", NP'(bus_rdata), NP'(32'hCAFE_0042));

        // R7: unmapped and level writes ignored, unmapped reads zero
        cur_tag = "R7";
        snap_out = pad_out; snap_oe = pad_oe;
        wr(0, 32'hFFFF_FFFF);
        wr(25, 32'hFFFF_FFFF);
        wr(1000, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        chk("R7 pad_out unchanged", pad_out, snap_out);
        chk("R7 pad_oe unchanged", pad_oe, snap_oe);
        rd(0, d);   chk("R7 read word0", NP'(d), '0);
        rd(25, d);  chk("R7 read word25", NP'(d), '0);
        rd(1023, d); chk("R7 read top word", NP'(d), '0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule